// File: doc/BRIEF.md
# Oscillator Stop Guard with Crystal Stabilization Status

This block holds the stop flags for three clock sources: a main crystal oscillator, a low-speed subsystem oscillator and an internal high-speed oscillator. A stop flag can always be cleared, which starts its source. A request to set a stop flag is granted only if the clock-select state shows that the source is not feeding the CPU and peripheral clock. A refused request leaves the flag as it was and raises a sticky error bit that software can read.

The block also measures how long the crystal has been running. A counter advances on each crystal cycle, marked by `xt_tick`, and fills an 8-bit status byte from the MSB downward as it passes successive powers of two. The counter starts when the crystal is started in crystal mode or when STOP mode is released. It is cleared by reset, by entry to STOP mode and by a granted request to stop the crystal.

The counter is a three-state machine. IDLE means cleared and not counting. COUNT means counting ticks. DONE means saturated. The transitions are: any state to IDLE on a clear event; any state to COUNT, with the count reset to zero, on a start event when no clear event occurs in the same cycle; COUNT to DONE on the tick that reaches the top threshold. Clear wins over start. DONE holds until the next clear or start event.

Top module: `osc_stop_guard`

## Requirements
- R1: Reset sets the control byte to 8'h03 (bit0 crystal stop = 1, bit1 subsystem stop = 1, bit2 internal stop = 0, bit7 error = 0) and the status byte to 8'h00.
- R2: A write of 1 to control bit0 (crystal stop) is granted only when `cls`=1 or `mcs`=0.
- R3: A write of 1 to control bit1 (subsystem stop) is granted only when `cls`=0.
- R4: A write of 1 to control bit2 (internal stop) is granted only when `cls`=1 or `mcs`=1.
- R5: A write of 0 to any stop bit always clears that bit.
- R6: A refused write of 1 leaves that flag unchanged and sets control bit7. Writing 1 to bit7 clears it, unless the same write is itself refused.
- R7: The status byte becomes 8'h00 one cycle after a `stop_enter` pulse and after a granted write of 1 to bit0. A refused write does not clear it.
- R8: Counting starts from zero when a write changes bit0 from 1 to 0 while `exclk`=0 and `oscsel`=1. The same write does not start counting in any other mode.
- R9: A `stop_exit` pulse restarts counting from zero.
- R10: The count advances only on cycles with `xt_tick`=1. Status bit 7-k is 1 once the count reaches 2^(MIN_EXP+k), so the bits fill from the MSB downward.
- R11: Once the status byte is 8'hFF it holds that value until a clear or start event.
- R12: Writes to the status address (`bus_addr`=1) change neither the status byte nor the control byte.
- R13: `bit_rdata` equals bit `bit_sel` of the register selected by `bus_addr` (0 = control, 1 = status), as read on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Byte read of the selected register |
| bit_sel | input | 3 | Bit index for single-bit read |
| bit_rdata | output | 1 | Single-bit read of the selected register |
| cls | input | 1 | 1: CPU clock comes from the subsystem oscillator |
| mcs | input | 1 | With cls=0: 1 selects the crystal, 0 the internal oscillator |
| exclk | input | 1 | 1: main input is an external clock, not a crystal |
| oscsel | input | 1 | 1: main oscillator pins are in use |
| stop_enter | input | 1 | One-cycle pulse on entry to STOP mode |
| stop_exit | input | 1 | One-cycle pulse on release from STOP mode |
| xt_tick | input | 1 | One crystal cycle has elapsed |
| main_stop | output | 1 | Stop enable for the crystal oscillator |
| sub_stop | output | 1 | Stop enable for the subsystem oscillator |
| hio_stop | output | 1 | Stop enable for the internal oscillator |

## Verification
The assertions check on every cycle that no stop flag rises unless the clock-select state permitted it. They also check that the status byte is always a thermometer code, that it is zero after a STOP entry, that it leaves 8'hFF only toward zero, and that it stays frozen on cycles with no tick, write or mode pulse. Some behaviours show only in the bench's scenarios: the exact threshold cycles, the rule that a refused write does not clear the status, start suppression outside crystal mode, writes ignored at the status address, and the single-bit read path.

// File: rtl/osg_pkg.sv
package osg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } stab_state_t;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    localparam int BIT_MAIN = 0;
    localparam int BIT_SUB  = 1;
    localparam int BIT_HIO  = 2;
    localparam int BIT_ERR  = 7;
endpackage

// File: rtl/osg_stop_ctrl.sv
module osg_stop_ctrl
    import osg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cls,
    input  logic              mcs,
    input  logic              exclk,
    input  logic              oscsel,
    output logic [DATA_W-1:0] ctrl_byte,
    output logic              main_q,
    output logic              sub_q,
    output logic              hio_q,
    output logic              xtal_clear,
    output logic              xtal_start
);
    logic err_q;
    logic main_d, sub_d, hio_d, err_d;
    logic main_ok, sub_ok, hio_ok, refused;

    // A source may stop only while it is not the CPU clock source
    assign main_ok = cls | ~mcs;
    assign sub_ok  = ~cls;
    assign hio_ok  = cls | mcs;

    always_comb begin
        refused = wr_ctrl & ((wdata[BIT_MAIN] & ~main_ok) |
                             (wdata[BIT_SUB]  & ~sub_ok)  |
                             (wdata[BIT_HIO]  & ~hio_ok));
        main_d = main_q;
        sub_d  = sub_q;
        hio_d  = hio_q;
        err_d  = err_q;
        if (wr_ctrl) begin
            main_d = wdata[BIT_MAIN] ? (main_ok ? 1'b1 : main_q) : 1'b0;
            sub_d  = wdata[BIT_SUB]  ? (sub_ok  ? 1'b1 : sub_q)  : 1'b0;
            hio_d  = wdata[BIT_HIO]  ? (hio_ok  ? 1'b1 : hio_q)  : 1'b0;
            err_d  = refused | (err_q & ~wdata[BIT_ERR]);
        end
    end

    assign xtal_clear = wr_ctrl & wdata[BIT_MAIN] & main_ok;
    assign xtal_start = wr_ctrl & ~wdata[BIT_MAIN] & main_q & ~exclk & oscsel;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q <= 1'b1;
            sub_q  <= 1'b1;
            hio_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            main_q <= main_d;
            sub_q  <= sub_d;
            hio_q  <= hio_d;
            err_q  <= err_d;
        end
    end

    always_comb begin
        ctrl_byte           = '0;
        ctrl_byte[BIT_MAIN] = main_q;
        ctrl_byte[BIT_SUB]  = sub_q;
        ctrl_byte[BIT_HIO]  = hio_q;
        ctrl_byte[BIT_ERR]  = err_q;
    end
endmodule

// File: rtl/osg_stab_fsm.sv
module osg_stab_fsm
    import osg_pkg::*;
#(
    parameter int MIN_EXP = 8,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              start,
    input  logic              tick,
    output logic [DATA_W-1:0] status
);
    localparam int CNT_W = MIN_EXP + DATA_W;
    localparam logic [CNT_W-1:0] TOP = {1'b1, {(CNT_W-1){1'b0}}};

    stab_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_COUNT: begin
                if (tick) begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q + CNT_W'(1) == TOP) state_d = ST_DONE;
                end
            end
            ST_DONE: ;
            default: state_d = ST_IDLE;
        endcase
        if (clear) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (start) begin
            state_d = ST_COUNT;
            cnt_d   = '0;
        end
    end

    for (genvar k = 0; k < DATA_W; k++) begin : g_thr
        localparam logic [CNT_W-1:0] THR = CNT_W'(1) << (MIN_EXP + k);
        assign status[DATA_W-1-k] = (cnt_q >= THR);
    end
endmodule

// File: rtl/osg_read_mux.sv
module osg_read_mux
    import osg_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              addr,
    input  logic [DATA_W-1:0] ctrl_byte,
    input  logic [DATA_W-1:0] stat_byte,
    input  logic [SEL_W-1:0]  bit_sel,
    output logic [DATA_W-1:0] rdata,
    output logic              rbit
);
    assign rdata = (addr == ADDR_STAT) ? stat_byte : ctrl_byte;
    assign rbit  = rdata[bit_sel];
endmodule

// File: rtl/osc_stop_guard.sv
module osc_stop_guard
    import osg_pkg::*;
#(
    parameter int MIN_EXP = 8,
    parameter int DATA_W  = 8,
    localparam int SEL_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SEL_W-1:0]  bit_sel,
    output logic              bit_rdata,
    input  logic              cls,
    input  logic              mcs,
    input  logic              exclk,
    input  logic              oscsel,
    input  logic              stop_enter,
    input  logic              stop_exit,
    input  logic              xt_tick,
    output logic              main_stop,
    output logic              sub_stop,
    output logic              hio_stop
);
    logic [DATA_W-1:0] ctrl_byte, stat_byte;
    logic              xtal_clear, xtal_start;
    logic              wr_ctrl;

    assign wr_ctrl = bus_wr & (bus_addr == ADDR_CTRL);

    osg_stop_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wdata      (bus_wdata),
        .cls        (cls),
        .mcs        (mcs),
        .exclk      (exclk),
        .oscsel     (oscsel),
        .ctrl_byte  (ctrl_byte),
        .main_q     (main_stop),
        .sub_q      (sub_stop),
        .hio_q      (hio_stop),
        .xtal_clear (xtal_clear),
        .xtal_start (xtal_start)
    );

    osg_stab_fsm #(.MIN_EXP(MIN_EXP), .DATA_W(DATA_W)) u_stab (
        .clk    (clk),
        .rst    (rst),
        .clear  (xtal_clear | stop_enter),
        .start  (xtal_start | stop_exit),
        .tick   (xt_tick),
        .status (stat_byte)
    );

    osg_read_mux #(.DATA_W(DATA_W)) u_rd (
        .addr      (bus_addr),
        .ctrl_byte (ctrl_byte),
        .stat_byte (stat_byte),
        .bit_sel   (bit_sel),
        .rdata     (bus_rdata),
        .rbit      (bit_rdata)
    );
endmodule

// File: rtl/osg_checker.sv
module osg_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       cls,
    input logic       mcs,
    input logic       stop_enter,
    input logic       stop_exit,
    input logic       xt_tick,
    input logic       main_stop,
    input logic       sub_stop,
    input logic       hio_stop
);
    logic [7:0] stat_view;
    always_comb begin
        stat_view = u_rd_stat;
    end
    logic [7:0] u_rd_stat;
    assign u_rd_stat = osc_stop_guard.stat_byte;

    // R2
    main_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(main_stop) |-> $past(cls | ~mcs));
    // R3
    sub_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sub_stop) |-> $past(~cls));
    // R4
    hio_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hio_stop) |-> $past(cls | mcs));
    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(stop_enter) |-> (stat_view == 8'h00));
    // R10
    thermo_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_view & ~{1'b1, stat_view[7:1]}) == 8'h00);
    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!xt_tick && !stop_enter && !stop_exit && !bus_wr)) |-> $stable(stat_view));
    // R11
    saturate_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_view) == 8'hFF) |-> (stat_view == 8'hFF || stat_view == 8'h00));
endmodule

bind osc_stop_guard osg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .cls        (cls),
    .mcs        (mcs),
    .stop_enter (stop_enter),
    .stop_exit  (stop_exit),
    .xt_tick    (xt_tick),
    .main_stop  (main_stop),
    .sub_stop   (sub_stop),
    .hio_stop   (hio_stop)
);

// File: tb/osc_stop_guard_bench.sv
module osc_stop_guard_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [2:0] bit_sel = 3'd0;
    logic       bit_rdata;
    logic       cls = 1'b0, mcs = 1'b0, exclk = 1'b0, oscsel = 1'b0;
    logic       stop_enter = 1'b0, stop_exit = 1'b0, xt_tick = 1'b1;
    logic       main_stop, sub_stop, hio_stop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    osc_stop_guard #(.MIN_EXP(2), .DATA_W(8)) u_osc_stop_guard (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_sel(bit_sel),
        .bit_rdata(bit_rdata), .cls(cls), .mcs(mcs), .exclk(exclk),
        .oscsel(oscsel), .stop_enter(stop_enter), .stop_exit(stop_exit),
        .xt_tick(xt_tick), .main_stop(main_stop), .sub_stop(sub_stop),
        .hio_stop(hio_stop)
    );

    // {cls, mcs, wdata, expected control byte}
    localparam logic [17:0] VEC [8] = '{
        {1'b0, 1'b0, 8'h00, 8'h00},  // R5 clear all
        {1'b0, 1'b0, 8'h01, 8'h01},  // R2 crystal stop granted
        {1'b0, 1'b0, 8'h04, 8'h80},  // R4 internal stop refused, R6
        {1'b0, 1'b0, 8'h82, 8'h02},  // R3 subsystem stop granted, R6 clear
        {1'b0, 1'b1, 8'h05, 8'h84},  // R2 refused, R4 granted
        {1'b1, 1'b0, 8'h82, 8'h80},  // R3 refused, error wins
        {1'b1, 1'b1, 8'h85, 8'h05},  // R2 R4 granted
        {1'b0, 1'b1, 8'h80, 8'h00}   // R5
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        cycles(3);
        rst = 1'b0;
        rd(1'b0, v); check8("R1 ctrl reset", v, 8'h03);
        rd(1'b1, v); check8("R1 status reset", v, 8'h00);

        for (int i = 0; i < 8; i++) begin
            cls = VEC[i][17];
            mcs = VEC[i][16];
            wr(1'b0, VEC[i][15:8]);
            rd(1'b0, v);
            check8($sformatf("R2/R3/R4/R5/R6 vector %0d", i), v, VEC[i][7:0]);
        end

        // Stabilization sequence in crystal mode
        cls = 1'b1; oscsel = 1'b1; exclk = 1'b0; xt_tick = 1'b1;
        wr(1'b0, 8'h01);
        rd(1'b1, v); check8("R7 granted crystal stop clears", v, 8'h00);
        wr(1'b0, 8'h00);
        cycles(3);
        rd(1'b1, v); check8("R8 R10 count 3", v, 8'h00);
        cycles(1);
        rd(1'b1, v); check8("R10 count 4", v, 8'h80);
        cycles(4);
        rd(1'b1, v); check8("R10 count 8", v, 8'hC0);

        xt_tick = 1'b0;
        cycles(20);
        rd(1'b1, v); check8("R10 no tick holds", v, 8'hC0);
        bit_sel = 3'd6; rd(1'b1, v);
        checks++; if (bit_rdata !== 1'b1) begin fails++; $display("FAIL R13 bit6 actual=%b expected=1", bit_rdata); end
        bit_sel = 3'd5; rd(1'b1, v);
        checks++; if (bit_rdata !== 1'b0) begin fails++; $display("FAIL R13 bit5 actual=%b expected=0", bit_rdata); end
        wr(1'b1, 8'h00);
        wr(1'b1, 8'hFF);
        rd(1'b1, v); check8("R12 status write ignored", v, 8'hC0);
        rd(1'b0, v); check8("R12 ctrl untouched", v, 8'h00);

        xt_tick = 1'b1;
        cycles(600);
        rd(1'b1, v); check8("R11 full", v, 8'hFF);
        cycles(50);
        rd(1'b1, v); check8("R11 saturated hold", v, 8'hFF);

        cls = 1'b0; mcs = 1'b1;
        wr(1'b0, 8'h01);
        rd(1'b1, v); check8("R7 refused write keeps status", v, 8'hFF);
        rd(1'b0, v); check8("R6 refused crystal stop", v, 8'h80);

        @(negedge clk); stop_enter = 1'b1;
        @(negedge clk); stop_enter = 1'b0;
        rd(1'b1, v); check8("R7 stop entry clears", v, 8'h00);
        @(negedge clk); stop_exit = 1'b1;
        @(negedge clk); stop_exit = 1'b0;
        cycles(4);
        rd(1'b1, v); check8("R9 stop release restarts", v, 8'h80);

        cls = 1'b1; oscsel = 1'b0;
        wr(1'b0, 8'h81);
        wr(1'b0, 8'h00);
        cycles(10);
        rd(1'b1, v); check8("R8 no start when oscsel=0", v, 8'h00);
        oscsel = 1'b1; exclk = 1'b1;
        wr(1'b0, 8'h01);
        wr(1'b0, 8'h00);
        cycles(10);
        rd(1'b1, v); check8("R8 no start with external clock", v, 8'h00);

        exclk = 1'b0;
        wr(1'b0, 8'h01);
        wr(1'b0, 8'h00);
        cycles(8);
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        rd(1'b1, v); check8("R1 status after mid-run reset", v, 8'h00);
        rd(1'b0, v); check8("R1 ctrl after mid-run reset", v, 8'h03);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule